// File: doc/BRIEF.md
# SDRAM Configuration Registers with Boot-Probe Address Folding

This block holds the software-visible configuration state of a simplified SDRAM controller and pairs it with a small address-folding decoder. Three banks of 32-bit registers sit behind one request/response bus: a common bank, a controller bank and a PHY bank. A two-bit bank select and a 12-bit byte offset choose the register. Every request is answered with a registered response one cycle later. Partial-width accesses and accesses outside a bank's register range return zero, store nothing and raise a one-cycle error flag.

Word 0 of the common bank is the geometry word. Writing it decodes three values: the row-address width, the bank-address width and the page size. The block compares the configured row width with the row width implied by the installed memory size, which is set by a parameter. If the two widths differ, a 4 KiB mirror window is enabled at the offset where a mis-sized device would wrap. Any memory address that falls inside that window is redirected to the same offset from the start of memory. A boot loader that writes a pattern at the row boundary and reads it back from address zero therefore sees the wrap it expects, and can work out the real size.

The controller bank also provides a minimal PHY bring-up handshake. A write to its word 0 immediately reports that initialisation is done and that the controller is active.

Top module: `sdram_cfg_regs`

## Requirements
- R1: Bank select 0 (common, 4 words), 1 (controller, 16 words) and 2 (PHY, 16 words) address words by byte offset bits [11:2]. A full-width read returns the last value written to that word.
- R2: The geometry word is common word 0. Its fields decode as follows: row width = bits[7:4]+1, bank width = bit[2]+2, page shift = bits[11:8]+3. When the mirror is enabled, it starts at MEM_BASE + 2^(actual_row + bank width + page shift), where actual_row = log2(MEM_MIB)+3.
- R3: A geometry write disables the mirror when MEM_MIB equals 2^(row width − 3). Any other row width, including widths below 3, enables it.
- R4: The decoder is combinational. alias_hit is 1 exactly when the mirror is enabled and mirror_start ≤ mem_addr_i < mirror_start + 4096. On a hit, mem_addr_o = MEM_BASE + (mem_addr_i − mirror_start); otherwise mem_addr_o = mem_addr_i.
- R5: The mirror enable and start take their new values on the same clock edge that captures the geometry write. At all other times they hold.
- R6: A full-width write to controller word 0 (offset 0x00) stores the data and, on the same edge, sets bit 0 of controller word 4 (offset 0x10) and bit 0 of controller word 6 (offset 0x18). The other bits of those words are kept.
- R7: An access with req_be other than 4'hF is rejected. It reads zero, changes no register and no mirror state, and raises rsp_err.
- R8: An access to a word index at or beyond its bank's size, or to bank select 3, reads zero, changes nothing and raises rsp_err. rsp_err is 1 for exactly the response of that request.
- R9: Reset (rst_n low) clears every register in all three banks and disables the mirror.
- R10: Each request cycle yields rsp_valid in the next cycle only; cycles without a request yield no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 2 | Bank select: 0 common, 1 controller, 2 PHY, 3 none |
| req_addr | input | 12 | Byte offset inside the bank |
| req_be | input | 4 | Byte enables; only 4'hF is accepted |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Request was rejected |
| mem_addr_i | input | MEM_AW | Memory address to be decoded |
| mem_addr_o | output | MEM_AW | Decoded (possibly folded) memory address |
| alias_hit | output | 1 | mem_addr_i fell in the enabled mirror window |

## Verification
A request presented in the cycle ending at clock edge N has its response (valid, data, error) visible from edge N until edge N+1. Register and mirror-state changes are also taken at edge N. A read issued in the next cycle therefore sees the new contents, and the decoder, being combinational, reflects the new mirror state right after edge N for whatever address is applied. The bench drives every input on the falling edge and compares all outputs against its model at the following falling edge. That places each comparison half a cycle after the edge that produced the result and before the next edge can alter it.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;

    typedef enum logic [1:0] {
        WIN_CMN  = 2'd0,
        WIN_CTL  = 2'd1,
        WIN_PHY  = 2'd2,
        WIN_NONE = 2'd3
    } win_e;

    // word indices whose behaviour is fixed
    localparam int unsigned CMN_GEOM_IDX  = 0;
    localparam int unsigned CTL_INIT_IDX  = 0;
    localparam int unsigned CTL_PSTAT_IDX = 4;
    localparam int unsigned CTL_STAT_IDX  = 6;

    localparam int unsigned MIRROR_BYTES = 4096;

    typedef struct packed {
        logic [4:0] row_w;
        logic [1:0] bank_w;
        logic [4:0] page_sh;
    } geom_t;

    function automatic geom_t decode_geom(input logic [31:0] w);
        geom_t g;
        g.row_w   = {1'b0, w[7:4]} + 5'd1;
        g.bank_w  = {1'b0, w[2]} + 2'd2;
        g.page_sh = {1'b0, w[11:8]} + 5'd3;
        return g;
    endfunction

endpackage

// File: rtl/sdram_cfg_regfile.sv
module sdram_cfg_regfile
    import sdram_cfg_pkg::*;
#(
    parameter int unsigned CMN_WORDS = 4,
    parameter int unsigned CTL_WORDS = 16,
    parameter int unsigned PHY_WORDS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_win,
    input  logic [11:0] req_addr,
    input  logic [3:0]  req_be,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_err,
    output logic        geom_we,
    output logic [31:0] geom_wdata
);

    localparam int unsigned CMN_AW = $clog2(CMN_WORDS);
    localparam int unsigned CTL_AW = $clog2(CTL_WORDS);
    localparam int unsigned PHY_AW = $clog2(PHY_WORDS);
    localparam logic [9:0]  CMN_LIM = 10'(CMN_WORDS);
    localparam logic [9:0]  CTL_LIM = 10'(CTL_WORDS);
    localparam logic [9:0]  PHY_LIM = 10'(PHY_WORDS);

    typedef struct packed {
        logic [CMN_WORDS-1:0][31:0] cmn;
        logic [CTL_WORDS-1:0][31:0] ctl;
        logic [PHY_WORDS-1:0][31:0] phy;
        logic                       rvalid;
        logic                       rerr;
        logic [31:0]                rdata;
    } rf_state_t;

    rf_state_t st_d, st_q;

    logic [9:0] word_idx;
    logic       full_word;
    logic       in_range;
    logic       accept;

    assign word_idx  = req_addr[11:2];
    assign full_word = (req_be == 4'hF);

    always_comb begin
        case (win_e'(req_win))
            WIN_CMN: in_range = (word_idx < CMN_LIM);
            WIN_CTL: in_range = (word_idx < CTL_LIM);
            WIN_PHY: in_range = (word_idx < PHY_LIM);
            default: in_range = 1'b0;
        endcase
    end

    assign accept = req_valid && full_word && in_range;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = req_valid;
        st_d.rerr   = req_valid && !accept;
        st_d.rdata  = '0;
        if (accept) begin
            if (!req_write) begin
                case (win_e'(req_win))
                    WIN_CMN: st_d.rdata = st_q.cmn[word_idx[CMN_AW-1:0]];
                    WIN_CTL: st_d.rdata = st_q.ctl[word_idx[CTL_AW-1:0]];
                    WIN_PHY: st_d.rdata = st_q.phy[word_idx[PHY_AW-1:0]];
                    default: st_d.rdata = '0;
                endcase
            end else begin
                case (win_e'(req_win))
                    WIN_CMN: st_d.cmn[word_idx[CMN_AW-1:0]] = req_wdata;
                    WIN_CTL: begin
                        if (word_idx == 10'(CTL_INIT_IDX)) begin
                            st_d.ctl[CTL_PSTAT_IDX][0] = 1'b1;
                            st_d.ctl[CTL_STAT_IDX][0]  = 1'b1;
                        end
                        st_d.ctl[word_idx[CTL_AW-1:0]] = req_wdata;
                    end
                    WIN_PHY: st_d.phy[word_idx[PHY_AW-1:0]] = req_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid  = st_q.rvalid;
    assign rsp_err    = st_q.rerr;
    assign rsp_rdata  = st_q.rdata;
    assign geom_we    = accept && req_write && (win_e'(req_win) == WIN_CMN)
                        && (word_idx == 10'(CMN_GEOM_IDX));
    assign geom_wdata = req_wdata;

endmodule

// File: rtl/sdram_alias_ctrl.sv
module sdram_alias_ctrl
    import sdram_cfg_pkg::*;
#(
    parameter int unsigned        MEM_AW   = 40,
    parameter logic [MEM_AW-1:0]  MEM_BASE = 'h4000_0000,
    parameter int unsigned        MEM_MIB  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              geom_we,
    input  logic [31:0]       geom_wdata,
    output logic              alias_en,
    output logic [MEM_AW-1:0] alias_base
);

    localparam int unsigned ACT_ROW = $clog2(MEM_MIB) + 3;
    localparam logic [MEM_AW-1:0] ONE = MEM_AW'(1);

    typedef struct packed {
        logic              en;
        logic [MEM_AW-1:0] base;
    } al_state_t;

    al_state_t al_d, al_q;
    geom_t     geom;
    logic [5:0] wrap_sh;
    logic       rows_match;

    assign geom       = decode_geom(geom_wdata);
    assign rows_match = (geom.row_w == 5'(ACT_ROW));
    assign wrap_sh    = 6'(ACT_ROW) + 6'(geom.bank_w) + 6'(geom.page_sh);

    always_comb begin
        al_d = al_q;
        if (geom_we) begin
            if (rows_match) begin
                al_d.en = 1'b0;
            end else begin
                al_d.en   = 1'b1;
                al_d.base = MEM_BASE + (ONE << wrap_sh);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            al_q <= '0;
        end else begin
            al_q <= al_d;
        end
    end

    assign alias_en   = al_q.en;
    assign alias_base = al_q.base;

endmodule

// File: rtl/sdram_alias_decode.sv
module sdram_alias_decode
    import sdram_cfg_pkg::*;
#(
    parameter int unsigned       MEM_AW   = 40,
    parameter logic [MEM_AW-1:0] MEM_BASE = 'h4000_0000
) (
    input  logic              alias_en,
    input  logic [MEM_AW-1:0] alias_base,
    input  logic [MEM_AW-1:0] addr_in,
    output logic [MEM_AW-1:0] addr_out,
    output logic              hit
);

    localparam logic [MEM_AW-1:0] SPAN = MEM_AW'(MIRROR_BYTES);

    logic [MEM_AW-1:0] delta;

    assign delta    = addr_in - alias_base;
    assign hit      = alias_en && (addr_in >= alias_base) && (delta < SPAN);
    assign addr_out = hit ? (MEM_BASE + delta) : addr_in;

endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
    import sdram_cfg_pkg::*;
#(
    parameter int unsigned       MEM_AW    = 40,
    parameter logic [MEM_AW-1:0] MEM_BASE  = 'h4000_0000,
    parameter int unsigned       MEM_MIB   = 256,
    parameter int unsigned       CMN_WORDS = 4,
    parameter int unsigned       CTL_WORDS = 16,
    parameter int unsigned       PHY_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_win,
    input  logic [11:0]       req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    input  logic [MEM_AW-1:0] mem_addr_i,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic              alias_hit
);

    logic              geom_we_w;
    logic [31:0]       geom_wdata_w;
    logic              alias_en_w;
    logic [MEM_AW-1:0] alias_base_w;

    sdram_cfg_regfile #(
        .CMN_WORDS (CMN_WORDS),
        .CTL_WORDS (CTL_WORDS),
        .PHY_WORDS (PHY_WORDS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_win    (req_win),
        .req_addr   (req_addr),
        .req_be     (req_be),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .rsp_err    (rsp_err),
        .geom_we    (geom_we_w),
        .geom_wdata (geom_wdata_w)
    );

    sdram_alias_ctrl #(
        .MEM_AW   (MEM_AW),
        .MEM_BASE (MEM_BASE),
        .MEM_MIB  (MEM_MIB)
    ) u_alias (
        .clk        (clk),
        .rst_n      (rst_n),
        .geom_we    (geom_we_w),
        .geom_wdata (geom_wdata_w),
        .alias_en   (alias_en_w),
        .alias_base (alias_base_w)
    );

    sdram_alias_decode #(
        .MEM_AW   (MEM_AW),
        .MEM_BASE (MEM_BASE)
    ) u_decode (
        .alias_en   (alias_en_w),
        .alias_base (alias_base_w),
        .addr_in    (mem_addr_i),
        .addr_out   (mem_addr_o),
        .hit        (alias_hit)
    );

endmodule

// File: rtl/sdram_cfg_chk.sv
module sdram_cfg_chk #(
    parameter int unsigned       MEM_AW   = 40,
    parameter logic [MEM_AW-1:0] MEM_BASE = 'h4000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_win,
    input logic [11:0]       req_addr,
    input logic [3:0]        req_be,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_err,
    input logic [MEM_AW-1:0] mem_addr_i,
    input logic [MEM_AW-1:0] mem_addr_o,
    input logic              alias_hit,
    input logic              alias_en
);

    localparam logic [MEM_AW-1:0] SPAN = MEM_AW'(4096);

    logic geom_wr;
    assign geom_wr = req_valid && req_write && (req_win == 2'd0)
                     && (req_addr[11:2] == 10'd0) && (req_be == 4'hF);

    assert_rsp_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_partial_rejected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_be != 4'hF) |=> (rsp_err && rsp_rdata == 32'd0));

    assert_bad_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_win == 2'd3) |=> rsp_err);

    assert_err_only_on_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == 32'd0));

    assert_hit_lands_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        alias_hit |-> ((mem_addr_o - MEM_BASE) < SPAN));

    assert_miss_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !alias_hit |-> (mem_addr_o == mem_addr_i));

    assert_hit_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        alias_hit |-> alias_en);

    assert_alias_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !geom_wr |=> $stable(alias_en));

endmodule

bind sdram_cfg_regs sdram_cfg_chk #(
    .MEM_AW   (MEM_AW),
    .MEM_BASE (MEM_BASE)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_win    (req_win),
    .req_addr   (req_addr),
    .req_be     (req_be),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err),
    .mem_addr_i (mem_addr_i),
    .mem_addr_o (mem_addr_o),
    .alias_hit  (alias_hit),
    .alias_en   (alias_en_w)
);

// File: tb/sdram_cfg_regs_tb_top.sv
`timescale 1ns/1ps
module sdram_cfg_regs_tb_top;

    localparam int unsigned AW   = 40;
    localparam logic [AW-1:0] BASE = 40'h00_4000_0000;
    localparam int unsigned MIB  = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_win = 2'd0;
    logic [11:0]   req_addr = 12'd0;
    logic [3:0]    req_be = 4'hF;
    logic [31:0]   req_wdata = 32'd0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          rsp_err;
    logic [AW-1:0] mem_addr_i = '0;
    logic [AW-1:0] mem_addr_o;
    logic          alias_hit;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    sdram_cfg_regs #(.MEM_AW(AW), .MEM_BASE(BASE), .MEM_MIB(MIB)) dut_i (
        .clk, .rst_n, .req_valid, .req_write, .req_win, .req_addr, .req_be,
        .req_wdata, .rsp_valid, .rsp_rdata, .rsp_err, .mem_addr_i, .mem_addr_o,
        .alias_hit
    );

    // behavioural reference
    logic [31:0] m_cmn [4];
    logic [31:0] m_ctl [16];
    logic [31:0] m_phy [16];
    bit          m_en;
    longint      m_base;

    task automatic model_clear();
        for (int i = 0; i < 4; i++)  m_cmn[i] = 32'd0;
        for (int i = 0; i < 16; i++) m_ctl[i] = 32'd0;
        for (int i = 0; i < 16; i++) m_phy[i] = 32'd0;
        m_en = 1'b0;
        m_base = 0;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic model_geom(input logic [31:0] w);
        int row, bank, psh, act;
        row  = int'((w >> 4) & 32'hF) + 1;
        bank = int'((w >> 2) & 32'h1) + 2;
        psh  = int'((w >> 8) & 32'hF) + 3;
        act  = $clog2(MIB) + 3;
        if (row >= 3 && MIB == (1 << (row - 3))) begin
            m_en = 1'b0;
        end else begin
            m_en = 1'b1;
            m_base = (longint'(BASE) + ((64'd1 << (act + bank)) * (64'd1 << psh)))
                     & 64'hFF_FFFF_FFFF;
        end
    endtask

    // one cycle: drive at falling edge, compare at the next falling edge
    task automatic step(input bit v, input bit w, input logic [1:0] win,
                        input logic [11:0] addr, input logic [3:0] be,
                        input logic [31:0] wd, input longint ma, input string req);
        bit ok;
        int idx;
        bit   e_err;
        logic [31:0] e_rd;
        bit   e_hit;
        longint e_ma;
        req_valid = v; req_write = w; req_win = win; req_addr = addr;
        req_be = be; req_wdata = wd; mem_addr_i = AW'(ma);
        idx = int'(addr[11:2]);
        ok = (be == 4'hF) && ((win == 2'd0 && idx < 4) || (win == 2'd1 && idx < 16)
                               || (win == 2'd2 && idx < 16));
        e_err = v && !ok;
        e_rd = 32'd0;
        if (v && ok) begin
            if (!w) begin
                case (win)
                    2'd0: e_rd = m_cmn[idx];
                    2'd1: e_rd = m_ctl[idx];
                    default: e_rd = m_phy[idx];
                endcase
            end else begin
                case (win)
                    2'd0: begin m_cmn[idx] = wd; if (idx == 0) model_geom(wd); end
                    2'd1: begin
                        if (idx == 0) begin
                            m_ctl[4][0] = 1'b1;
                            m_ctl[6][0] = 1'b1;
                        end
                        m_ctl[idx] = wd;
                    end
                    default: m_phy[idx] = wd;
                endcase
            end
        end
        e_hit = m_en && (ma >= m_base) && (ma < m_base + 4096);
        e_ma  = e_hit ? (longint'(BASE) + (ma - m_base)) : ma;
        @(negedge clk);
        check(rsp_valid == v, (v ? req : "R10"), "rsp_valid", longint'(rsp_valid), longint'(v));
        check(rsp_err == e_err, req, "rsp_err", longint'(rsp_err), longint'(e_err));
        check(rsp_rdata == e_rd, req, "rsp_rdata", longint'(rsp_rdata), longint'(e_rd));
        check(alias_hit == e_hit, req, "alias_hit", longint'(alias_hit), longint'(e_hit));
        check(longint'(mem_addr_o) == e_ma, req, "mem_addr_o", longint'(mem_addr_o), e_ma);
        req_valid = 1'b0;
    endtask

    task automatic idle(input longint ma, input string req);
        step(1'b0, 1'b0, 2'd0, 12'd0, 4'hF, 32'd0, ma, req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        model_clear();
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    longint b1;

    initial begin
        model_clear();
        @(negedge clk);
        do_reset();
        // R9: everything reads back zero, mirror off
        step(1, 0, 2'd0, 12'h000, 4'hF, 0, longint'(BASE) + 64'h10_0000, "R9");
        step(1, 0, 2'd1, 12'h010, 4'hF, 0, longint'(BASE) + 64'h8_0000, "R9");
        step(1, 0, 2'd1, 12'h018, 4'hF, 0, longint'(BASE), "R9");
        step(1, 0, 2'd2, 12'h00C, 4'hF, 0, longint'(BASE) + 64'h100_0000, "R9");
        idle(longint'(BASE), "R10");

        // R1: plain storage in each bank
        step(1, 1, 2'd2, 12'h00C, 4'hF, 32'hDEAD_BEEF, 0, "R1");
        step(1, 1, 2'd0, 12'h008, 4'hF, 32'h1234_5678, 0, "R1");
        step(1, 1, 2'd1, 12'h03C, 4'hF, 32'hCAFE_0001, 0, "R1");
        step(1, 0, 2'd2, 12'h00C, 4'hF, 0, 0, "R1");
        step(1, 0, 2'd0, 12'h008, 4'hF, 0, 0, "R1");
        step(1, 0, 2'd1, 12'h03C, 4'hF, 0, 0, "R1");
        step(1, 0, 2'd2, 12'h008, 4'hF, 0, 0, "R1");

        // R2/R5: row 13, bank 3, page shift 5 -> start = BASE + 2^19
        b1 = longint'(BASE) + 64'h8_0000;
        step(1, 1, 2'd0, 12'h000, 4'hF, 32'h0000_02C4, b1, "R5");
        step(1, 0, 2'd0, 12'h000, 4'hF, 0, b1 + 64'hFFF, "R2");
        idle(b1 + 64'h1000, "R4");
        idle(b1 - 1, "R4");
        idle(b1 + 64'h123, "R4");
        idle(longint'(BASE) + 64'h123, "R4");

        // R7: partial geometry write leaves mirror and word alone
        step(1, 1, 2'd0, 12'h000, 4'h7, 32'h0000_00A0, b1 + 64'h40, "R7");
        step(1, 0, 2'd0, 12'h000, 4'hF, 0, b1 + 64'h40, "R7");
        step(1, 0, 2'd0, 12'h000, 4'h1, 0, b1, "R7");

        // R3: matching row width (field 10 -> row 11) turns the mirror off
        step(1, 1, 2'd0, 12'h000, 4'hF, 32'h0000_02A4, b1, "R3");
        idle(b1 + 64'h10, "R3");

        // R3/R2: row field 0 -> row 1, bank 2, page shift 11 -> BASE + 2^24
        step(1, 1, 2'd0, 12'h000, 4'hF, 32'h0000_0800, longint'(BASE) + 64'h100_0010, "R3");
        idle(longint'(BASE) + 64'h100_0FFF, "R2");
        idle(longint'(BASE) + 64'h8_0000, "R2");

        // R6: PHY-init handshake keeps other bits of the status words
        step(1, 1, 2'd1, 12'h010, 4'hF, 32'h0000_00A0, 0, "R6");
        step(1, 1, 2'd1, 12'h000, 4'hF, 32'h0000_0005, 0, "R6");
        step(1, 0, 2'd1, 12'h010, 4'hF, 0, 0, "R6");
        step(1, 0, 2'd1, 12'h018, 4'hF, 0, 0, "R6");
        step(1, 0, 2'd1, 12'h000, 4'hF, 0, 0, "R6");
        step(1, 1, 2'd1, 12'h010, 4'hF, 32'h0000_0000, 0, "R6");
        step(1, 0, 2'd1, 12'h010, 4'hF, 0, 0, "R6");

        // R7: partial write to controller word dropped
        step(1, 1, 2'd1, 12'h014, 4'h3, 32'hFFFF_FFFF, 0, "R7");
        step(1, 0, 2'd1, 12'h014, 4'hF, 0, 0, "R7");

        // R8: out-of-range indices and bank 3
        step(1, 1, 2'd0, 12'h010, 4'hF, 32'h5555_AAAA, 0, "R8");
        step(1, 0, 2'd0, 12'h010, 4'hF, 0, 0, "R8");
        step(1, 0, 2'd0, 12'h000, 4'hF, 0, 0, "R8");
        step(1, 1, 2'd1, 12'h040, 4'hF, 32'h7777_7777, 0, "R8");
        step(1, 0, 2'd1, 12'h000, 4'hF, 0, 0, "R8");
        step(1, 1, 2'd2, 12'h7FC, 4'hF, 32'h9999_9999, 0, "R8");
        step(1, 0, 2'd3, 12'h000, 4'hF, 0, 0, "R8");
        step(1, 1, 2'd3, 12'h000, 4'hF, 32'h0000_02C4, longint'(BASE) + 64'h100_0000, "R8");
        idle(0, "R8");

        // R9: reset in the middle of a run
        do_reset();
        step(1, 0, 2'd1, 12'h010, 4'hF, 0, longint'(BASE) + 64'h100_0000, "R9");
        step(1, 0, 2'd2, 12'h00C, 4'hF, 0, longint'(BASE) + 64'h100_0004, "R9");
        step(1, 0, 2'd0, 12'h000, 4'hF, 0, 0, "R9");
        idle(0, "R10");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule